// File: doc/BRIEF.md
# Power-State and Wake Manager for a Network Controller

This block holds the power state of a network controller (D0, D1, D2, D3hot, D3cold) and turns that state, together with a small set of wake settings, into four activity gates: DMA, interrupts, PHY power and packet reception. When a wake event that software has enabled arrives while PME is enabled, it latches a PME status bit, records the cause and pulls an active-low PME line until software clears the status. The PME enable and status bits are sticky across the register reset that happens when the device leaves D3hot. Only a power-on reset clears them.

Software reaches four 32-bit registers through a simple write port. Reads are combinational from the address. Address 0 is the power-management control/status register. Address 1 is the wake control/status register. Address 2 holds the receive filter control. Address 3 holds the PHY interrupt control. The block runs on an always-on clock. A clock-present flag tells it whether configuration accesses can happen, and a bus-power flag tells it when the bus has dropped into D3cold.

The control flow is a five-state machine:
- ST_D0 moves to ST_D1, ST_D2 or ST_D3HOT when that state code is written.
- ST_D1 and ST_D2 move to any written state code.
- ST_D3HOT moves to ST_D3COLD when bus power drops ("power loss"). It returns to ST_D0 on a write of any code other than 3 ("exit with reset").
- ST_D3COLD leaves only through the power-on reset.

Top module: `pm_wake_ctrl`

## Requirements
- R1: After power-on reset (rst_n low) the state is D0. Every register reads 0, except the link-change mask at address 3 bit 5, which reads 1. pme_n is high.
- R2: Address 0 holds the state code in bits [1:0] (0=D0, 1=D1, 2=D2, 3=D3hot; D3cold reads 3), PME enable in bit 8 and PME status in bit 15. Writing 1 to bit 15 clears PME status. From D0, D1 or D2, writing the state code moves to that state on the next clock.
- R3: In D0, dma_en, irq_en, phy_pwr_en and rx_en are all 1. In every other state, dma_en and irq_en are 0.
- R4: In D1 and D2, phy_pwr_en is 1 and rx_en equals the inverse of rxfifo_full.
- R5: In D3hot and D3cold, phy_pwr_en is 1 only when PME enable is 1 and wake is armed. rx_en additionally requires rxfifo_full to be 0.
- R6: Address 1 enables wake on PHY link change (bit 0), pattern match (bit 1) and magic packet (bit 9). Address 2 bit 31 is the receive filter enable. Address 3 holds the PHY interrupt enable (bit 1) and the link-change mask (bit 5, 1 = masked). An event counts only if the filter is enabled and the event's bit is enabled. A link-change event also needs the PHY interrupt enable set and the mask clear. "Armed" means at least one event can count.
- R7: When an event counts and PME enable is 1, PME status and the cause bit are set on that clock. The cause bits sit at address 1: bit 16 for link change, bit 17 for pattern match, bit 18 for magic packet. Cause bits are write-1-to-clear. pme_n is low exactly while PME status and PME enable are both 1. With PME enable at 0, events change nothing.
- R8: If a write-1-to-clear and a counting event fall in the same clock, the set wins for both PME status and the cause bit.
- R9: In D3hot, writing a state code other than 3 moves to D0. Addresses 1 to 3 return to their reset values. PME enable and PME status are not reset; they take that write as usual.
- R10: In D3hot, bus_pwr_ok low moves to D3cold on the next clock. D3cold ignores all writes and is left only by rst_n.
- R11: Writes are ignored while pci_clk_present is 0. Wake events are still handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| pci_clk_present | input | 1 | Configuration clock running; writes accepted only when 1 |
| bus_pwr_ok | input | 1 | Bus power present; low in D3hot enters D3cold |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address for writes and reads |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| phy_irq_pulse | input | 1 | PHY link-change event |
| pattern_pulse | input | 1 | Pattern-match event |
| magic_pulse | input | 1 | Magic-packet event |
| rxfifo_full | input | 1 | Receive FIFO is full |
| dma_en | output | 1 | DMA allowed |
| irq_en | output | 1 | Interrupts allowed |
| phy_pwr_en | output | 1 | PHY powered |
| rx_en | output | 1 | Reception allowed |
| pme_n | output | 1 | Power-management event, active low |

## Verification
A wake event can land in the same clock as the software write that clears PME status or the cause bit. The bench provokes this directly by driving a magic-packet pulse together with a write of bit 15 to address 0. It then reads back that status and pme_n stay asserted.

The same overlap also arises in the long random run, where event pulses and writes to any address are drawn each cycle. A bench model applies "set wins" and the sticky PME rules, and it is compared against every output and the read data on every clock.

// File: rtl/pm_wake_pkg.sv
`timescale 1ns/1ps
package pm_wake_pkg;
    localparam int unsigned REG_W   = 32;
    localparam int unsigned ADDR_W  = 2;
    localparam int unsigned NUM_EVT = 3;   // 0 link change, 1 pattern, 2 magic

    typedef enum logic [2:0] {
        ST_D0     = 3'd0,
        ST_D1     = 3'd1,
        ST_D2     = 3'd2,
        ST_D3HOT  = 3'd3,
        ST_D3COLD = 3'd4
    } pstate_e;

    localparam logic [ADDR_W-1:0] A_PMCSR = 2'd0;
    localparam logic [ADDR_W-1:0] A_WAKE  = 2'd1;
    localparam logic [ADDR_W-1:0] A_FILT  = 2'd2;
    localparam logic [ADDR_W-1:0] A_PHYC  = 2'd3;

    localparam int unsigned PM_EN_BIT  = 8;
    localparam int unsigned PM_STS_BIT = 15;
    localparam int unsigned FILT_BIT   = 31;
    localparam int unsigned PHY_IE_BIT = 1;
    localparam int unsigned PHY_MK_BIT = 5;
    localparam int unsigned CAUSE_LSB  = 16;

    function automatic int unsigned wake_en_bit(int unsigned idx);
        case (idx)
            0:       return 0;
            1:       return 1;
            default: return 9;
        endcase
    endfunction
endpackage

// File: rtl/pm_wake_evt.sv
`timescale 1ns/1ps
module pm_wake_evt (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_clear,
    input  logic enable,
    input  logic path_ok,
    input  logic pulse,
    input  logic pme_en,
    input  logic w1c,
    output logic hit,
    output logic cause
);
    logic cause_q;

    assign hit   = pulse & enable & path_ok;
    assign cause = cause_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cause_q <= 1'b0;
        else
            cause_q <= (cfg_clear ? 1'b0 : (cause_q & ~w1c)) | (hit & pme_en);
    end

    // R8: a counted event is never lost to a clear in the same cycle
    p_cause_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && pme_en) |=> cause);
endmodule

// File: rtl/pm_wake_regs.sv
`timescale 1ns/1ps
module pm_wake_regs
    import pm_wake_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ok,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [REG_W-1:0]   wdata,
    input  logic               cfg_clear,
    input  logic [NUM_EVT-1:0] evt_pulse,
    output logic               req_valid,
    output logic [1:0]         req_state,
    output logic               pme_en,
    output logic               pme_sts,
    output logic               filt_en,
    output logic               phy_ie,
    output logic               phy_mask,
    output logic [NUM_EVT-1:0] wake_en,
    output logic [NUM_EVT-1:0] cause,
    output logic               wake_armed
);
    logic               wr_pm, wr_wake, wr_filt, wr_phyc;
    logic [NUM_EVT-1:0] path_ok, hit;
    logic               any_hit;
    logic               pme_en_q, pme_sts_q, filt_q, ie_q, mask_q;

    assign wr_pm   = wr_ok && (addr == A_PMCSR);
    assign wr_wake = wr_ok && (addr == A_WAKE);
    assign wr_filt = wr_ok && (addr == A_FILT);
    assign wr_phyc = wr_ok && (addr == A_PHYC);

    assign req_valid = wr_pm;
    assign req_state = wdata[1:0];

    assign any_hit = (|hit) & pme_en_q;

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        localparam int unsigned EB = wake_en_bit(i);
        logic en_q;

        if (i == 0) begin : g_link
            assign path_ok[i] = filt_q & ie_q & ~mask_q;
        end else begin : g_plain
            assign path_ok[i] = filt_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         en_q <= 1'b0;
            else if (cfg_clear) en_q <= 1'b0;
            else if (wr_wake)   en_q <= wdata[EB];
        end
        assign wake_en[i] = en_q;

        pm_wake_evt u_evt (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_clear (cfg_clear),
            .enable    (en_q),
            .path_ok   (path_ok[i]),
            .pulse     (evt_pulse[i]),
            .pme_en    (pme_en_q),
            .w1c       (wr_wake & wdata[CAUSE_LSB+i]),
            .hit       (hit[i]),
            .cause     (cause[i])
        );
    end

    // PME bits: untouched by cfg_clear, only power-on reset clears them
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pme_en_q  <= 1'b0;
            pme_sts_q <= 1'b0;
        end else begin
            if (wr_pm) pme_en_q <= wdata[PM_EN_BIT];
            pme_sts_q <= (pme_sts_q & ~(wr_pm & wdata[PM_STS_BIT])) | any_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
            ie_q   <= 1'b0;
            mask_q <= 1'b1;
        end else if (cfg_clear) begin
            filt_q <= 1'b0;
            ie_q   <= 1'b0;
            mask_q <= 1'b1;
        end else begin
            if (wr_filt) filt_q <= wdata[FILT_BIT];
            if (wr_phyc) begin
                ie_q   <= wdata[PHY_IE_BIT];
                mask_q <= wdata[PHY_MK_BIT];
            end
        end
    end

    assign pme_en     = pme_en_q;
    assign pme_sts    = pme_sts_q;
    assign filt_en    = filt_q;
    assign phy_ie     = ie_q;
    assign phy_mask   = mask_q;
    assign wake_armed = |(wake_en & path_ok);

    // R7: status stays set until a write-1-to-clear
    p_sts_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pme_sts && !(wr_pm && wdata[PM_STS_BIT])) |=> pme_sts);
    // R8: a counted event sets status even against a clear
    p_sts_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|hit) && pme_en) |=> pme_sts);
    // R7: with PME disabled an event cannot raise status
    p_no_set_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pme_en && !pme_sts) |=> !pme_sts);
endmodule

// File: rtl/pm_power_fsm.sv
`timescale 1ns/1ps
module pm_power_fsm
    import pm_wake_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_state,
    input  logic       bus_pwr_ok,
    input  logic       pme_en,
    input  logic       wake_armed,
    input  logic       rxfifo_full,
    output pstate_e    state,
    output logic       cfg_clear,
    output logic       cold,
    output logic       dma_en,
    output logic       irq_en,
    output logic       phy_pwr_en,
    output logic       rx_en
);
    pstate_e state_q, state_d;
    logic    keep_alive;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_D0;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        cfg_clear = 1'b0;
        unique case (state_q)
            ST_D0, ST_D1, ST_D2: begin
                if (req_valid) begin
                    unique case (req_state)
                        2'd0:    state_d = ST_D0;
                        2'd1:    state_d = ST_D1;
                        2'd2:    state_d = ST_D2;
                        default: state_d = ST_D3HOT;
                    endcase
                end
            end
            ST_D3HOT: begin
                if (!bus_pwr_ok) begin
                    state_d = ST_D3COLD;
                end else if (req_valid && (req_state != 2'd3)) begin
                    state_d   = ST_D0;
                    cfg_clear = 1'b1;
                end
            end
            ST_D3COLD: state_d = ST_D3COLD;
            default:   state_d = ST_D0;
        endcase
    end

    assign keep_alive = pme_en & wake_armed;

    always_comb begin
        dma_en     = 1'b0;
        irq_en     = 1'b0;
        phy_pwr_en = 1'b0;
        rx_en      = 1'b0;
        unique case (state_q)
            ST_D0: begin
                dma_en     = 1'b1;
                irq_en     = 1'b1;
                phy_pwr_en = 1'b1;
                rx_en      = 1'b1;
            end
            ST_D1, ST_D2: begin
                phy_pwr_en = 1'b1;
                rx_en      = ~rxfifo_full;
            end
            ST_D3HOT, ST_D3COLD: begin
                phy_pwr_en = keep_alive;
                rx_en      = keep_alive & ~rxfifo_full;
            end
            default: ;
        endcase
    end

    assign state = state_q;
    assign cold  = (state_q == ST_D3COLD);

    // R10: D3cold is only left through reset
    p_cold_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_D3COLD) |=> (state_q == ST_D3COLD));
    // R3: a request to leave D0 shuts DMA and interrupts the next cycle
    p_leave_d0_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_D0 && req_valid && req_state != 2'd0) |=> (!dma_en && !irq_en));
    // R10: power loss in D3hot reaches D3cold
    p_power_loss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_D3HOT && !bus_pwr_ok) |=> cold);
endmodule

// File: rtl/pm_wake_ctrl.sv
`timescale 1ns/1ps
module pm_wake_ctrl
    import pm_wake_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pci_clk_present,
    input  logic        bus_pwr_ok,
    input  logic        cfg_wr,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        phy_irq_pulse,
    input  logic        pattern_pulse,
    input  logic        magic_pulse,
    input  logic        rxfifo_full,
    output logic        dma_en,
    output logic        irq_en,
    output logic        phy_pwr_en,
    output logic        rx_en,
    output logic        pme_n
);
    pstate_e            state;
    logic               cold, cfg_clear, wr_ok;
    logic               req_valid;
    logic [1:0]         req_state;
    logic               pme_en, pme_sts, filt_en, phy_ie, phy_mask, wake_armed;
    logic [NUM_EVT-1:0] wake_en, cause;
    logic [1:0]         state_code;

    assign wr_ok = cfg_wr & pci_clk_present & ~cold;

    pm_wake_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ok      (wr_ok),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .cfg_clear  (cfg_clear),
        .evt_pulse  ({magic_pulse, pattern_pulse, phy_irq_pulse}),
        .req_valid  (req_valid),
        .req_state  (req_state),
        .pme_en     (pme_en),
        .pme_sts    (pme_sts),
        .filt_en    (filt_en),
        .phy_ie     (phy_ie),
        .phy_mask   (phy_mask),
        .wake_en    (wake_en),
        .cause      (cause),
        .wake_armed (wake_armed)
    );

    pm_power_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_state   (req_state),
        .bus_pwr_ok  (bus_pwr_ok),
        .pme_en      (pme_en),
        .wake_armed  (wake_armed),
        .rxfifo_full (rxfifo_full),
        .state       (state),
        .cfg_clear   (cfg_clear),
        .cold        (cold),
        .dma_en      (dma_en),
        .irq_en      (irq_en),
        .phy_pwr_en  (phy_pwr_en),
        .rx_en       (rx_en)
    );

    always_comb begin
        unique case (state)
            ST_D0:   state_code = 2'd0;
            ST_D1:   state_code = 2'd1;
            ST_D2:   state_code = 2'd2;
            default: state_code = 2'd3;
        endcase
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_addr)
            A_PMCSR: begin
                cfg_rdata[1:0]        = state_code;
                cfg_rdata[PM_EN_BIT]  = pme_en;
                cfg_rdata[PM_STS_BIT] = pme_sts;
            end
            A_WAKE: begin
                for (int i = 0; i < NUM_EVT; i++) begin
                    cfg_rdata[wake_en_bit(i)] = wake_en[i];
                    cfg_rdata[CAUSE_LSB+i]    = cause[i];
                end
            end
            A_FILT: cfg_rdata[FILT_BIT] = filt_en;
            default: begin
                cfg_rdata[PHY_IE_BIT] = phy_ie;
                cfg_rdata[PHY_MK_BIT] = phy_mask;
            end
        endcase
    end

    assign pme_n = ~(pme_sts & pme_en);

    // R7: pme_n falls only after an event or after PME enable rises
    p_pme_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pme_n) |-> ($past(phy_irq_pulse | pattern_pulse | magic_pulse) || $rose(pme_en)));
    // R9: leaving D3hot empties the configuration registers
    p_exit_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_D3HOT && state == ST_D0) |-> (!filt_en && wake_en == '0 && phy_mask));
    // R11: without the configuration clock nothing is written
    p_noclk_nowrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !pci_clk_present |=> ($stable(filt_en) && $stable(phy_ie) && $stable(wake_en)));
    // R5: deep states keep the PHY off while PME is disabled
    p_d3_phy_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_D3HOT || state == ST_D3COLD) && !pme_en) |-> !phy_pwr_en);
endmodule

// File: tb/pm_wake_ctrl_tb.sv
`timescale 1ns/1ps
module pm_wake_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pci_clk_present = 1'b1;
    logic        bus_pwr_ok = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        phy_irq_pulse = 1'b0, pattern_pulse = 1'b0, magic_pulse = 1'b0;
    logic        rxfifo_full = 1'b0;
    logic        dma_en, irq_en, phy_pwr_en, rx_en, pme_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model of the register state
    int       m_st;
    logic     m_pen, m_psts, m_filt, m_ie, m_mask;
    logic [2:0] m_wen, m_cause;

    always #2 clk = ~clk;   // 250 MHz

    pm_wake_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .pci_clk_present(pci_clk_present),
        .bus_pwr_ok(bus_pwr_ok), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .phy_irq_pulse(phy_irq_pulse), .pattern_pulse(pattern_pulse),
        .magic_pulse(magic_pulse), .rxfifo_full(rxfifo_full),
        .dma_en(dma_en), .irq_en(irq_en), .phy_pwr_en(phy_pwr_en),
        .rx_en(rx_en), .pme_n(pme_n)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic m_armed();
        return m_filt && ((m_wen[0] && m_ie && !m_mask) || m_wen[1] || m_wen[2]);
    endfunction

    function automatic logic [31:0] m_read(logic [1:0] a);
        logic [31:0] r = '0;
        case (a)
            2'd0: begin
                r[1:0] = (m_st == 4) ? 2'd3 : 2'(m_st);
                r[8] = m_pen; r[15] = m_psts;
            end
            2'd1: begin
                r[0] = m_wen[0]; r[1] = m_wen[1]; r[9] = m_wen[2];
                r[18:16] = m_cause;
            end
            2'd2: r[31] = m_filt;
            default: begin r[1] = m_ie; r[5] = m_mask; end
        endcase
        return r;
    endfunction

    task automatic model_reset();
        m_st = 0; m_pen = 0; m_psts = 0; m_filt = 0; m_ie = 0; m_mask = 1;
        m_wen = '0; m_cause = '0;
    endtask

    // one clock of the requirements, from the inputs now applied
    task automatic model_step();
        logic wok, wpm, clr;
        logic [2:0] hit, w1c;
        int nst;
        wok = cfg_wr && pci_clk_present && (m_st != 4);               // R11 R10
        wpm = wok && cfg_addr == 2'd0;
        hit[0] = phy_irq_pulse && m_wen[0] && m_filt && m_ie && !m_mask; // R6
        hit[1] = pattern_pulse && m_wen[1] && m_filt;
        hit[2] = magic_pulse && m_wen[2] && m_filt;
        clr = 1'b0;
        nst = m_st;
        if (m_st < 3) begin
            if (wpm) nst = int'(cfg_wdata[1:0]);                        // R2
        end else if (m_st == 3) begin
            if (!bus_pwr_ok) nst = 4;                                   // R10
            else if (wpm && cfg_wdata[1:0] != 2'd3) begin nst = 0; clr = 1; end // R9
        end
        w1c = (wok && cfg_addr == 2'd1) ? cfg_wdata[18:16] : 3'b0;
        m_psts = (m_psts && !(wpm && cfg_wdata[15])) || (m_pen && |hit); // R7 R8
        m_cause = (clr ? 3'b0 : (m_cause & ~w1c)) | (hit & {3{m_pen}});
        if (wpm) m_pen = cfg_wdata[8];
        if (clr) begin
            m_wen = '0; m_filt = 0; m_ie = 0; m_mask = 1;
        end else begin
            if (wok && cfg_addr == 2'd1) m_wen = {cfg_wdata[9], cfg_wdata[1], cfg_wdata[0]};
            if (wok && cfg_addr == 2'd2) m_filt = cfg_wdata[31];
            if (wok && cfg_addr == 2'd3) begin m_ie = cfg_wdata[1]; m_mask = cfg_wdata[5]; end
        end
        m_st = nst;
    endtask

    task automatic check_outputs();
        string t;
        logic live;
        t = (m_st == 0) ? "R3" : (m_st < 3) ? "R4" : "R5";
        live = m_pen && m_armed();
        chk("R3 dma_en", dma_en, (m_st == 0));
        chk("R3 irq_en", irq_en, (m_st == 0));
        chk({t, " phy_pwr_en"}, phy_pwr_en, (m_st < 3) ? 1'b1 : live);
        chk({t, " rx_en"}, rx_en, (m_st == 0) ? 1'b1 : (m_st < 3) ? !rxfifo_full : (live && !rxfifo_full));
        chk("R7 pme_n", pme_n, !(m_psts && m_pen));
        chk((cfg_addr == 0) ? "R2 rdata" : "R6 rdata", cfg_rdata, m_read(cfg_addr));
    endtask

    // inputs set after a falling edge; one rising edge; check; strobes cleared
    task automatic cycle();
        @(posedge clk);
        model_step();
        #1;
        check_outputs();
        @(negedge clk);
        cfg_wr = 0; phy_irq_pulse = 0; pattern_pulse = 0; magic_pulse = 0;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
        cycle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; cfg_wr = 0;
        model_reset();
        #1;
        for (int a = 0; a < 4; a++) begin
            cfg_addr = 2'(a);
            #0.1;
            chk("R1 reset rdata", cfg_rdata, (a == 3) ? 32'h20 : 32'h0);
        end
        chk("R1 reset pme_n", pme_n, 1'b1);
        chk("R1 reset dma_en", dma_en, 1'b1);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic peek(logic [1:0] a, string req, logic [31:0] exp);
        cfg_addr = a;
        #0.1;
        chk(req, cfg_rdata, exp);
    endtask

    initial begin
        model_reset();
        void'($urandom(32'h5eed_1234));
        do_reset();

        // magic-packet wake in D3hot (R5 R6 R7)
        wr(2, 32'h8000_0000);
        wr(1, 32'h0000_0200);
        wr(0, 32'h0000_8103);
        chk("R5 phy kept on when armed", phy_pwr_en, 1'b1);
        magic_pulse = 1; cycle();
        chk("R7 pme_n low after magic", pme_n, 1'b0);
        peek(1, "R7 magic cause bit 18", 32'h0004_0200);

        // clear and new event in one cycle (R8)
        cfg_wr = 1; cfg_addr = 0; cfg_wdata = 32'h0000_8103; magic_pulse = 1;
        cycle();
        chk("R8 pme_n held when set meets clear", pme_n, 1'b0);
        wr(0, 32'h0000_8103);
        chk("R7 pme_n released by clear", pme_n, 1'b1);

        // fifo full stops reception in D3hot (R5)
        rxfifo_full = 1; cycle();
        chk("R5 rx_en off when fifo full", rx_en, 1'b0);
        rxfifo_full = 0;

        // leave D3hot: config cleared, PME enable kept (R9)
        wr(0, 32'h0000_0100);
        peek(2, "R9 filter cleared", 32'h0);
        peek(0, "R9 pme enable kept", 32'h0000_0100);

        // writes ignored without configuration clock (R11)
        pci_clk_present = 0;
        wr(2, 32'h8000_0000);
        pci_clk_present = 1;
        peek(2, "R11 write ignored", 32'h0);

        // link-change path needs unmask (R6)
        wr(2, 32'h8000_0000);
        wr(1, 32'h0000_0001);
        wr(3, 32'h0000_0022);
        phy_irq_pulse = 1; cycle();
        chk("R6 masked link change ignored", pme_n, 1'b1);
        wr(3, 32'h0000_0002);
        phy_irq_pulse = 1; cycle();
        chk("R6 unmasked link change wakes", pme_n, 1'b0);
        wr(0, 32'h0000_8101);

        // D1 reception against fifo (R4)
        rxfifo_full = 1; cycle();
        chk("R4 D1 rx off when full", rx_en, 1'b0);
        chk("R4 D1 dma off", dma_en, 1'b0);
        rxfifo_full = 0;

        // D3cold entry and write lockout (R10)
        wr(0, 32'h0000_0103);
        bus_pwr_ok = 0; cycle();
        bus_pwr_ok = 1;
        wr(0, 32'h0000_0100);
        peek(0, "R10 D3cold keeps state", 32'h0000_0103);

        // random phase
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            if (n % 300 == 299) do_reset();
            cfg_wr          = ($urandom % 3) == 0;
            cfg_addr        = 2'($urandom % 4);
            cfg_wdata       = $urandom;
            pci_clk_present = ($urandom % 8) != 0;
            bus_pwr_ok      = ($urandom % 20) != 0;
            phy_irq_pulse   = ($urandom % 5) == 0;
            pattern_pulse   = ($urandom % 6) == 0;
            magic_pulse     = ($urandom % 6) == 0;
            rxfifo_full     = ($urandom % 4) == 0;
            cycle();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule